// File: doc/BRIEF.md
# Daisy-Chain LED Frame Transmitter

This block sits on the controller side of a string of serially chained three-channel LED sink drivers. Each driver holds a three-stage shift register and a three-bit output latch; the serial data leaving one driver feeds the next one down the string. Given a parallel word with three enable bits per driver and a one-cycle start strobe, the block produces the serial clock, serial data and latch waveforms that load every driver of the string in a single frame. It also drives the string's blanking line from a registered request input and flags the end of each frame.

The serial clock is derived from the system clock by a phase counter. Each clock phase lasts a fixed number of system cycles, never fewer than the number needed to keep both phases at or above 20 ns, which also holds the serial rate at or below 25 MHz. Data moves on the falling serial edge so it sits half a period on each side of the sampling rising edge. The latch pulse follows the final falling edge with a half-period gap and lasts a half period.

Top module: `led_chain_tx`

## Requirements
- R1: A frame contains exactly 3·N_DEV rising serial-clock edges, followed by exactly one latch pulse.
- R2: Word bits are sent from bit 3·N_DEV-1 down to bit 0, so that after the latch pulse driver d (d = 0 nearest the controller) holds frame_word[3d+2:3d], with bit 3d+2 in the stage that receives the first of its three bits.
- R3: While a frame runs, every high and every low serial-clock phase lasts exactly HALF system cycles, where HALF is the larger of the requested divider and ceil(20 ns / system period).
- R4: Serial data changes only in the cycle the serial clock falls (or at frame start while the clock is low); it is constant through each high phase and across each rising edge.
- R5: The latch output rises HALF cycles after the last falling serial edge, stays high exactly HALF cycles, and the serial clock stays low throughout.
- R6: busy rises in the cycle after an accepted start and falls in the same cycle the latch falls; a start strobe seen while busy is ignored and changes neither the frame length nor the latched data.
- R7: done is high for exactly one cycle, in the cycle the latch output returns low, and is otherwise low.
- R8: The blank output follows the blank request input with one cycle of delay, regardless of frame activity.
- R9: During and after reset the serial clock, data, latch, busy and done outputs are low and the blank output is high.
- R10: From the cycle a start is accepted to the cycle done is seen, exactly (2·3·N_DEV + 2)·HALF cycles elapse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to transmit frame_word |
| frame_word | input | 3·N_DEV | Enable bits, three per driver, driver 0 in the low bits |
| blank_req | input | 1 | Request to blank all drivers |
| ser_clk | output | 1 | Serial clock to the first driver |
| ser_data | output | 1 | Serial data to the first driver |
| ser_latch | output | 1 | Latch strobe to the first driver |
| ser_blank | output | 1 | Blanking line to the first driver (high = all off) |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |

## Verification
The bench carries its own model of four chained drivers, each shifting on the rising serial edge and passing its top stage on at the falling edge, so a transmitter that reversed the word or the within-driver order would leave the wrong bits in nearly every driver; rotating per-driver values and walking-one patterns expose that. It measures every clock phase, the setup gap and the latch width in system cycles, catching a divider off by one or a latch raised before the last falling edge. A second start injected mid-frame with a complemented word must neither restart nor corrupt the frame, and the end-of-frame cycle count is compared against the formula so an extra or missing serial bit shows up as a length error.

// File: rtl/led_chain_pkg.sv
package led_chain_pkg;

    // channels carried by each chained driver
    localparam int CH_PER_DEV = 3;
    // shortest allowed serial clock phase; covers both the 18 ns phase
    // minimum and the 25 MHz rate limit (40 ns period)
    localparam int SER_MIN_PHASE_NS = 20;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_LSETUP,
        ST_LPULSE
    } tx_state_e;

    typedef struct packed {
        logic sclk;
        logic sdata;
        logic latch;
    } ser_pins_t;

    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/led_chain_pacer.sv
module led_chain_pacer #(
    parameter int HALF = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic tick
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = en && (cnt == LAST);

endmodule

// File: rtl/led_chain_seq.sv
module led_chain_seq
    import led_chain_pkg::*;
#(
    parameter int FRAME_BITS = 12
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic [FRAME_BITS-1:0] word,
    input  logic                  tick,
    output logic                  active,
    output logic                  busy,
    output logic                  done,
    output ser_pins_t             pins
);
    localparam int NW = $clog2(FRAME_BITS + 1);
    localparam logic [NW-1:0] LAST_BIT = NW'(FRAME_BITS);

    tx_state_e             state;
    logic [FRAME_BITS-1:0] sreg;
    logic [NW-1:0]         nbits;
    logic                  sclk_q;
    logic                  latch_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            sreg    <= '0;
            nbits   <= '0;
            sclk_q  <= 1'b0;
            latch_q <= 1'b0;
            busy    <= 1'b0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        sreg  <= word;
                        nbits <= '0;
                        busy  <= 1'b1;
                        state <= ST_SHIFT;
                    end
                end
                ST_SHIFT: begin
                    if (tick) begin
                        if (!sclk_q) begin
                            sclk_q <= 1'b1;
                            nbits  <= nbits + 1'b1;
                        end else begin
                            sclk_q <= 1'b0;
                            sreg   <= {sreg[FRAME_BITS-2:0], 1'b0};
                            if (nbits == LAST_BIT) begin
                                state <= ST_LSETUP;
                            end
                        end
                    end
                end
                ST_LSETUP: begin
                    if (tick) begin
                        latch_q <= 1'b1;
                        state   <= ST_LPULSE;
                    end
                end
                ST_LPULSE: begin
                    if (tick) begin
                        latch_q <= 1'b0;
                        busy    <= 1'b0;
                        done    <= 1'b1;
                        state   <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign active     = (state != ST_IDLE);
    assign pins.sclk  = sclk_q;
    assign pins.sdata = sreg[FRAME_BITS-1];
    assign pins.latch = latch_q;

endmodule

// File: rtl/led_chain_tx.sv
module led_chain_tx
    import led_chain_pkg::*;
#(
    parameter int N_DEV         = 4,
    parameter int SYS_PERIOD_NS = 5,
    parameter int HALF_REQ      = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        start,
    input  logic [CH_PER_DEV*N_DEV-1:0] frame_word,
    input  logic                        blank_req,
    output logic                        ser_clk,
    output logic                        ser_data,
    output logic                        ser_latch,
    output logic                        ser_blank,
    output logic                        busy,
    output logic                        done
);
    localparam int FRAME_BITS = CH_PER_DEV * N_DEV;
    localparam int MIN_HALF   = ceil_div(SER_MIN_PHASE_NS, SYS_PERIOD_NS);
    localparam int HALF       = max_int(HALF_REQ, MIN_HALF);

    logic      active;
    logic      tick;
    ser_pins_t pins;

    led_chain_pacer #(.HALF(HALF)) u_pacer (
        .clk  (clk),
        .rst  (rst),
        .en   (active),
        .tick (tick)
    );

    led_chain_seq #(.FRAME_BITS(FRAME_BITS)) u_seq (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .word   (frame_word),
        .tick   (tick),
        .active (active),
        .busy   (busy),
        .done   (done),
        .pins   (pins)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ser_blank <= 1'b1;
        end else begin
            ser_blank <= blank_req;
        end
    end

    assign ser_clk   = pins.sclk;
    assign ser_data  = pins.sdata;
    assign ser_latch = pins.latch;

endmodule

// File: rtl/led_chain_chk.sv
module led_chain_chk #(
    parameter int FRAME_BITS = 12,
    parameter int HALF       = 4
) (
    input logic clk,
    input logic rst,
    input logic start,
    input logic ser_clk,
    input logic ser_data,
    input logic ser_latch,
    input logic busy,
    input logic done
);
    localparam int RW = 16;

    logic          prev_clk;
    logic [RW-1:0] run;
    logic [RW-1:0] rises;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_clk <= 1'b0;
            run      <= '0;
            rises    <= '0;
        end else begin
            prev_clk <= ser_clk;
            if (ser_clk != prev_clk) begin
                run <= RW'(1);
            end else if (run != {RW{1'b1}}) begin
                run <= run + 1'b1;
            end
            if (!busy) begin
                rises <= '0;
            end else if (ser_clk && !prev_clk) begin
                rises <= rises + 1'b1;
            end
        end
    end

    // R3: no serial clock phase is shorter than HALF cycles
    a_r3_phase_min: assert property (@(posedge clk) disable iff (rst)
        (ser_clk != prev_clk) |-> (run >= RW'(HALF)));

    // R4: data holds across the rising edge and the high phase
    a_r4_data_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(ser_clk) |-> $stable(ser_data));
    a_r4_data_high: assert property (@(posedge clk) disable iff (rst)
        (ser_clk && $past(ser_clk)) |-> $stable(ser_data));

    // R5: serial clock stays low while the latch is high
    a_r5_latch_clk_low: assert property (@(posedge clk) disable iff (rst)
        ser_latch |-> !ser_clk);

    // R1: a full frame of rising edges precedes the latch
    a_r1_bits_before_latch: assert property (@(posedge clk) disable iff (rst)
        $rose(ser_latch) |-> (rises == RW'(FRAME_BITS)));

    // R6: busy covers the latch and only rises after a start
    a_r6_latch_in_busy: assert property (@(posedge clk) disable iff (rst)
        ser_latch |-> busy);
    a_r6_busy_from_start: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));

    // R7: done is a single cycle marking the latch falling
    a_r7_done_at_latch_fall: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> ($fell(ser_latch) && !busy));
    a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

endmodule

bind led_chain_tx led_chain_chk #(
    .FRAME_BITS(FRAME_BITS),
    .HALF      (HALF)
) i_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .ser_clk   (ser_clk),
    .ser_data  (ser_data),
    .ser_latch (ser_latch),
    .busy      (busy),
    .done      (done)
);

// File: tb/test_led_chain_tx.sv
`timescale 1ns/1ps
module test_led_chain_tx;
    localparam int N  = 4;
    localparam int W  = 3 * N;
    localparam int H  = 4;
    localparam int EXP_LEN = (2 * W + 2) * H + 1;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [W-1:0] frame_word = '0;
    logic         blank_req = 1'b0;
    logic         ser_clk, ser_data, ser_latch, ser_blank, busy, done;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    led_chain_tx #(.N_DEV(N), .SYS_PERIOD_NS(5), .HALF_REQ(H)) i_led_chain_tx (
        .clk(clk), .rst(rst), .start(start), .frame_word(frame_word),
        .blank_req(blank_req), .ser_clk(ser_clk), .ser_data(ser_data),
        .ser_latch(ser_latch), .ser_blank(ser_blank), .busy(busy), .done(done)
    );

    // behavioural model of the chained drivers
    logic [2:0] dsr  [N];
    logic       dout [N];
    logic [2:0] dlat [N];

    initial begin
        for (int d = 0; d < N; d++) begin
            dsr[d] = '0; dout[d] = 1'b0; dlat[d] = '0;
        end
    end

    always @(posedge ser_clk) begin
        for (int d = 0; d < N; d++)
            dsr[d] <= {dsr[d][1:0], (d == 0) ? ser_data : dout[d-1]};
    end
    always @(negedge ser_clk) begin
        for (int d = 0; d < N; d++) dout[d] <= dsr[d][2];
    end
    always @(negedge ser_latch) begin
        for (int d = 0; d < N; d++) dlat[d] <= dsr[d];
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_frame(input logic [W-1:0] w, input bit inject);
        int cyc = 0, rises = 0, last_chg = 0, last_fall = 0;
        int lrise = -1, lfall = -1, done_cyc = -1;
        int phase_bad = 0, data_bad = 0, lclk_bad = 0, nchg = 0;
        logic p_clk, p_data, p_latch;
        @(negedge clk);
        frame_word = w;
        start = 1'b1;
        p_clk = ser_clk; p_data = ser_data; p_latch = ser_latch;
        while (done_cyc < 0 && cyc < 2000) begin
            @(negedge clk);
            cyc++;
            start = inject && (cyc == 40);
            if (inject && cyc == 40) frame_word = ~w;
            if (cyc == 1) check(busy == 1'b1, "R6 busy after start", busy, 1);
            if (ser_clk != p_clk) begin
                nchg++;
                if (nchg > 1 && (cyc - last_chg) != H) phase_bad++;
                last_chg = cyc;
                if (ser_clk) rises++; else last_fall = cyc;
            end
            if (ser_data != p_data && ser_clk) data_bad++;
            if (ser_latch && ser_clk) lclk_bad++;
            if (ser_latch && !p_latch) lrise = cyc;
            if (!ser_latch && p_latch) lfall = cyc;
            if (done) begin
                done_cyc = cyc;
                check(busy == 1'b0, "R6 busy low at end", busy, 0);
                check(!ser_latch && p_latch, "R7 done with latch fall", ser_latch, 0);
            end
            p_clk = ser_clk; p_data = ser_data; p_latch = ser_latch;
        end
        start = 1'b0;
        check(rises == W, "R1 rising edges", rises, W);
        check(phase_bad == 0, "R3 phase length", phase_bad, 0);
        check(data_bad == 0, "R4 data stable high", data_bad, 0);
        check(lrise - last_fall == H, "R5 latch setup", lrise - last_fall, H);
        check(lfall - lrise == H, "R5 latch width", lfall - lrise, H);
        check(lclk_bad == 0, "R5 clock low in latch", lclk_bad, 0);
        check(done_cyc == EXP_LEN, "R10 frame length", done_cyc, EXP_LEN);
        @(negedge clk);
        check(done == 1'b0, "R7 done one cycle", done, 0);
        for (int d = 0; d < N; d++)
            check(dlat[d] == w[3*d +: 3], $sformatf("R2 driver %0d bits", d),
                  dlat[d], w[3*d +: 3]);
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [W-1:0] w;
        repeat (3) @(negedge clk);
        // R9: reset state
        check(!ser_clk && !ser_data && !ser_latch, "R9 serial pins low", {ser_clk, ser_data, ser_latch}, 0);
        check(!busy && !done, "R9 busy done low", {busy, done}, 0);
        check(ser_blank == 1'b1, "R9 blank high", ser_blank, 1);
        rst = 1'b0;
        @(negedge clk);
        // R8: blank follows request
        blank_req = 1'b0;
        @(negedge clk);
        check(ser_blank == 1'b0, "R8 blank follows low", ser_blank, 0);
        run_frame('0, 1'b0);
        run_frame('1, 1'b0);
        // rotating per-driver values: every driver sees every 3-bit code
        for (int k = 0; k < 8; k++) begin
            w = '0;
            for (int d = 0; d < N; d++) w[3*d +: 3] = 3'((k + 3 * d) % 8);
            run_frame(w, 1'b0);
        end
        for (int b = 0; b < W; b++) run_frame(W'(1) << b, 1'b0);
        // R6: start while busy ignored
        run_frame(12'hA5C, 1'b1);
        blank_req = 1'b1;
        @(negedge clk);
        check(ser_blank == 1'b1, "R8 blank follows high", ser_blank, 1);
        run_frame(12'h3E1, 1'b0);
        check(ser_blank == 1'b1, "R8 blank held over frame", ser_blank, 1);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule